// File: doc/BRIEF.md
# Register-Loaded SPI Frame Shifter

This block runs one single-lane SPI frame at a time under register control. Software fills a small bank of transmit bytes, writes the frame length as a number of bits, and then sets the start bit of the command register. The engine pulls chip select low and sends the loaded bytes MSB-first on the data-out line, highest-numbered byte first. On every clock it also captures the data-in line into a receive bank. When the programmed number of bits has been clocked, it raises chip select again, clears its busy flag and gives a one-cycle done pulse.

The serial clock is produced by dividing the system clock. Each half period lasts `HALF_PERIOD` system cycles, and the bus runs in mode 0. Transmit positions beyond the loaded bytes go out as zeros. The receive bank behaves as one long shift register, so byte 0 always holds the most recent eight bits. A build option, `EXTRA_SAMPLE`, adds one clock to frames that software marks as receive-type. This leaves room for a device that returns its data late.

Register map (5-bit address, 8-bit data):
- `0x00`: command. Bit 2 is start, and it reads back as busy. Bit 3 is the receive hint. Bits 0 and 4 are reserved.
- `0x01`: bit count.
- `0x08 + n`: transmit byte n, for n = 0 to 5.
- `0x10 + n`: receive byte n, for n = 0 to 9, read only.

Top module: `regspi_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck`, `spi_mosi`, `busy` and `done` are 0. Every register reads 0, with read data appearing one cycle after the address.
- R2: Writing the command register at 0x00 with bit 2 set while idle starts a frame. While the frame runs, reading 0x00 returns 0x04; afterwards it returns 0x00. A write with only bit 0 or bit 4 set does not start anything.
- R3: The count register at 0x01 holds a bit count. A written value above 56 is stored as 56. A frame of count N produces exactly N rising edges on `spi_sck`.
- R4: Data-out bits go MSB-first. They start with transmit byte 5 (0x0D) and continue down to byte 0 (0x08). Every bit after the 48th is 0.
- R5: Data-in is sampled on each rising SCK edge and shifted into a bank cleared at start. Receive byte 0 (0x10) holds the last eight bits sampled, byte 1 (0x11) the eight before those, and so on. Positions not reached read 0.
- R6: Mode 0 timing applies. SCK idles low and is high only while chip select is low. Data-out never changes while SCK is high. Each SCK high phase lasts `HALF_PERIOD` system cycles.
- R7: While busy, writes to the count and transmit registers are ignored. A further start request is also ignored and does not launch a second frame.
- R8: `done` is high for exactly one cycle, in the first cycle that `busy` reads 0 after a frame. A frame with count 0 gives `done` without ever lowering chip select or toggling SCK.
- R9: With `EXTRA_SAMPLE` = 1 and command bit 3 set at start, the frame has count+1 SCK pulses, all sampled into the receive bank. Without bit 3, or with `EXTRA_SAMPLE` = 0, the frame has exactly count pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Registered read data, one cycle after `rd_addr` |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses a bit count of 12 to catch a receive bank that is aligned to the first received bit instead of the last. Such a design would split the bits between bytes 0 and 1 wrongly. A count written as 200 must come back as 56 and clock out eight trailing zero bits; a design that truncates the count instead would run a short frame. Writes and a second start issued mid-frame must leave the count, the transmit byte and the pulse total unchanged, which exposes a register file that ignores `busy`. Two further cases target the end of the frame. A zero-length frame must complete without chip select ever falling. A second instance built with the extra-sample option must add exactly one pulse, and only when the receive hint is set, so an off-by-one in the frame length shows up as a wrong receive byte.

// File: rtl/regspi_pkg.sv
package regspi_pkg;
  localparam int ADDR_W       = 5;
  localparam int DATA_W       = 8;
  localparam logic [ADDR_W-1:0] ADDR_CMD     = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_COUNT   = 5'h01;
  localparam int  ADDR_TX_BASE = 8;
  localparam int  ADDR_RX_BASE = 16;
  localparam int  CMD_START_BIT  = 2;
  localparam int  CMD_RXHINT_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_TAIL = 2'd3
  } shift_state_t;
endpackage

// File: rtl/regspi_clkdiv.sv
module regspi_clkdiv #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  generate
    if (HALF_PERIOD <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      assign tick = run && (cnt_q == CNT_W'(HALF_PERIOD - 1));
      always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(HALF_PERIOD - 1));
    end
  endgenerate
endmodule

// File: rtl/regspi_regs.sv
module regspi_regs
  import regspi_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int CNT_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     busy,
  input  logic [RX_BYTES*8-1:0]    rx_vec,
  output logic [TX_BYTES*8-1:0]    tx_vec,
  output logic [CNT_W-1:0]         bit_count,
  output logic                     start,
  output logic                     rx_hint
);
  logic [7:0]       tx_mem [TX_BYTES];
  logic [CNT_W-1:0] count_q;
  logic [7:0]       rd_next;
  logic             wr_ok;

  assign wr_ok   = wr_en && !busy;
  assign start   = wr_ok && (wr_addr == ADDR_CMD) && wr_data[CMD_START_BIT];
  assign rx_hint = wr_data[CMD_RXHINT_BIT];
  assign bit_count = count_q;

  genvar gi;
  generate
    for (gi = 0; gi < TX_BYTES; gi++) begin : g_txvec
      assign tx_vec[gi*8 +: 8] = tx_mem[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      for (int k = 0; k < TX_BYTES; k++) tx_mem[k] <= '0;
    end else if (wr_ok) begin
      if (wr_addr == ADDR_COUNT) begin
        if (wr_data > DATA_W'(MAX_BITS)) count_q <= CNT_W'(MAX_BITS);
        else                             count_q <= wr_data[CNT_W-1:0];
      end
      for (int k = 0; k < TX_BYTES; k++)
        if (wr_addr == ADDR_W'(ADDR_TX_BASE + k)) tx_mem[k] <= wr_data;
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_CMD)   rd_next[CMD_START_BIT] = busy;
    if (rd_addr == ADDR_COUNT) rd_next = DATA_W'(count_q);
    for (int k = 0; k < TX_BYTES; k++)
      if (rd_addr == ADDR_W'(ADDR_TX_BASE + k)) rd_next = tx_mem[k];
    for (int k = 0; k < RX_BYTES; k++)
      if (rd_addr == ADDR_W'(ADDR_RX_BASE + k)) rd_next = rx_vec[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(MAX_BITS));
  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(count_q));
  assert_tx_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(tx_vec));
endmodule

// File: rtl/regspi_shifter.sv
module regspi_shifter
  import regspi_pkg::*;
#(
  parameter int TX_BYTES     = 6,
  parameter int RX_BYTES     = 10,
  parameter int CNT_W        = 6,
  parameter bit EXTRA_SAMPLE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  rx_hint,
  input  logic [TX_BYTES*8-1:0] tx_vec,
  input  logic [CNT_W-1:0]      bit_count,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  busy,
  output logic                  done,
  output logic [RX_BYTES*8-1:0] rx_vec
);
  localparam int TXW = TX_BYTES * 8;
  localparam int RXW = RX_BYTES * 8;

  shift_state_t     state_q;
  logic [TXW-1:0]   tx_sr;
  logic [RXW-1:0]   rx_sr;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] rise_cnt;

  assign total  = bit_count + CNT_W'(EXTRA_SAMPLE && rx_hint);
  assign rx_vec = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tx_sr    <= '0;
      rx_sr    <= '0;
      left_q   <= '0;
      total_q  <= '0;
      rise_cnt <= '0;
      sck      <= 1'b0;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            tx_sr    <= tx_vec;
            rx_sr    <= '0;
            left_q   <= total;
            total_q  <= total;
            rise_cnt <= '0;
            if (total == '0) begin
              state_q <= ST_TAIL;
            end else begin
              state_q <= ST_LOW;
              cs_n    <= 1'b0;
              mosi    <= tx_vec[TXW-1];
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            sck      <= 1'b1;
            rx_sr    <= {rx_sr[RXW-2:0], miso};
            rise_cnt <= rise_cnt + 1'b1;
            state_q  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck    <= 1'b0;
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              mosi    <= 1'b0;
              state_q <= ST_TAIL;
            end else begin
              mosi    <= tx_sr[TXW-2];
              tx_sr   <= {tx_sr[TXW-2:0], 1'b0};
              state_q <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_sck_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);
  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
  assert_done_edge_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_pulse_total_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rise_cnt == total_q));
  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck));
endmodule

// File: rtl/regspi_engine.sv
module regspi_engine
  import regspi_pkg::*;
#(
  parameter int TX_BYTES     = 6,
  parameter int RX_BYTES     = 10,
  parameter int MAX_BITS     = 56,
  parameter int HALF_PERIOD  = 2,
  parameter bit EXTRA_SAMPLE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [4:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(MAX_BITS + 2);

  logic                  start;
  logic                  rx_hint;
  logic                  tick;
  logic [TX_BYTES*8-1:0] tx_vec;
  logic [RX_BYTES*8-1:0] rx_vec;
  logic [CNT_W-1:0]      bit_count;

  regspi_regs #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES),
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .rx_vec(rx_vec),
    .tx_vec(tx_vec), .bit_count(bit_count),
    .start(start), .rx_hint(rx_hint)
  );

  regspi_clkdiv #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  regspi_shifter #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES),
    .CNT_W(CNT_W), .EXTRA_SAMPLE(EXTRA_SAMPLE)
  ) u_shift (
    .clk(clk), .rst(rst),
    .start(start), .rx_hint(rx_hint),
    .tx_vec(tx_vec), .bit_count(bit_count),
    .tick(tick), .miso(spi_miso),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .busy(busy), .done(done), .rx_vec(rx_vec)
  );
endmodule

// File: tb/test_regspi_engine.sv
module test_regspi_engine;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data, rd_data_l;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic busy, done;
  logic sck_l, cs_n_l, mosi_l, busy_l, done_l;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  regspi_engine #(.HALF_PERIOD(HALF)) i_regspi_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .busy(busy), .done(done));

  regspi_engine #(.HALF_PERIOD(HALF), .EXTRA_SAMPLE(1'b1)) i_regspi_engine_late (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_l),
    .spi_sck(sck_l), .spi_cs_n(cs_n_l), .spi_mosi(mosi_l),
    .spi_miso(1'b1), .busy(busy_l), .done(done_l));

  // Monitors
  int pulses = 0, pulses_l = 0, cs_falls = 0, done_cnt = 0;
  int hi_run = 0, last_hi = 0;
  logic [127:0] cap_bits = '0;
  always @(posedge spi_sck) begin pulses++; cap_bits = {cap_bits[126:0], spi_mosi}; end
  always @(posedge sck_l) pulses_l++;
  always @(negedge spi_cs_n) cs_falls++;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (spi_sck) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // Slave model: next bit after each falling SCK
  int slv_cnt = 0;
  int slv_base = 0;
  logic [127:0] slv_pat = '0;
  always @(negedge spi_sck) slv_cnt++;
  always_comb begin
    int idx;
    idx = slv_cnt - slv_base;
    if (idx < 0 || idx > 127) spi_miso = 1'b0;
    else spi_miso = slv_pat[127 - idx];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  int p0, pl0, c0, d0;
  task automatic launch(input logic [7:0] cmd);
    p0 = pulses; pl0 = pulses_l; c0 = cs_falls; d0 = done_cnt;
    slv_base = slv_cnt;
    wr(5'h00, cmd);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy && !busy_l) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic load_tx(input logic [47:0] v);
    for (int k = 0; k < 6; k++) wr(5'(8 + k), v[k*8 +: 8]);
  endtask

  function automatic logic [127:0] exp_mosi(input logic [47:0] v, input int n);
    logic [127:0] e = '0;
    for (int i = 0; i < n; i++) e = {e[126:0], (i < 48) ? v[47 - i] : 1'b0};
    return e;
  endfunction

  function automatic logic [79:0] exp_rx(input logic [127:0] pat, input int n);
    logic [79:0] e = '0;
    for (int i = 0; i < n; i++) e = {e[78:0], pat[127 - i]};
    return e;
  endfunction

  function automatic logic [127:0] mask(input int n);
    logic [127:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check_rx(input string req, input logic [79:0] e);
    logic [7:0] b;
    for (int k = 0; k < 10; k++) begin
      rd(5'(16 + k), b);
      chk(req, 64'(b), 64'(e[k*8 +: 8]));
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 cs_n", 64'(spi_cs_n), 64'd1);
    chk("R1 sck/mosi", 64'({spi_sck, spi_mosi}), 64'd0);
    chk("R1 busy/done", 64'({busy, done}), 64'd0);
    rd(5'h00, b); chk("R1 cmd", 64'(b), 64'd0);
    rd(5'h01, b); chk("R1 count", 64'(b), 64'd0);
    rd(5'h0D, b); chk("R1 tx5", 64'(b), 64'd0);
    rd(5'h10, b); chk("R1 rx0", 64'(b), 64'd0);
  endtask

  task automatic t_full_frame();
    logic [47:0] v = 48'hA53C_96F0_1E87;
    logic [7:0] b;
    load_tx(v);
    wr(5'h01, 8'd48);
    slv_pat = {64'hC3_5A_71_E4_0F_B6_29_D8, 64'h0};
    launch(8'h04);
    repeat (4) @(negedge clk);
    chk("R2 busy", 64'(busy), 64'd1);
    rd(5'h00, b); chk("R2 cmd busy readback", 64'(b), 64'h04);
    wait_idle();
    rd(5'h00, b); chk("R2 cmd cleared", 64'(b), 64'h00);
    chk("R3 pulses 48", 64'(pulses - p0), 64'd48);
    chk("R4 mosi order", 64'(cap_bits & mask(48)), 64'(exp_mosi(v, 48)));
    check_rx("R5 rx bank 48", exp_rx(slv_pat, 48));
    chk("R6 high phase", 64'(last_hi), 64'(HALF));
    chk("R6 one cs fall", 64'(cs_falls - c0), 64'd1);
    chk("R8 single done", 64'(done_cnt - d0), 64'd1);
  endtask

  task automatic t_partial();
    logic [47:0] v = 48'h5F00_0000_0000;
    load_tx(v);
    wr(5'h01, 8'd12);
    slv_pat = {16'hB7D0, 112'h0};
    launch(8'h04);
    wait_idle();
    chk("R3 pulses 12", 64'(pulses - p0), 64'd12);
    chk("R4 mosi 12 bits", 64'(cap_bits & mask(12)), 64'(exp_mosi(v, 12)));
    check_rx("R5 rx aligned to last bit", exp_rx(slv_pat, 12));
  endtask

  task automatic t_saturate();
    logic [47:0] v = 48'hFF_FF_FF_FF_FF_FF;
    logic [7:0] b;
    load_tx(v);
    wr(5'h01, 8'd200);
    rd(5'h01, b); chk("R3 count saturates", 64'(b), 64'd56);
    slv_pat = {64'h1122_3344_5566_7788, 64'h0};
    launch(8'h04);
    wait_idle();
    chk("R3 pulses 56", 64'(pulses - p0), 64'd56);
    chk("R4 zero fill", 64'(cap_bits & mask(56)), 64'(exp_mosi(v, 56)));
    check_rx("R5 rx 56", exp_rx(slv_pat, 56));
  endtask

  task automatic t_reserved();
    wr(5'h01, 8'd8);
    launch(8'h11);
    repeat (20) @(negedge clk);
    chk("R2 reserved bits no start busy", 64'(busy), 64'd0);
    chk("R2 reserved bits no pulses", 64'(pulses - p0), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] b;
    wr(5'h0D, 8'h3A);
    wr(5'h01, 8'd24);
    launch(8'h04);
    wr(5'h01, 8'd5);
    wr(5'h0D, 8'hEE);
    wr(5'h00, 8'h04);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R7 no restart", 64'(busy), 64'd0);
    chk("R7 pulses unchanged", 64'(pulses - p0), 64'd24);
    rd(5'h01, b); chk("R7 count kept", 64'(b), 64'd24);
    rd(5'h0D, b); chk("R7 tx kept", 64'(b), 64'h3A);
  endtask

  task automatic t_zero();
    wr(5'h01, 8'd0);
    launch(8'h04);
    wait_idle();
    chk("R8 zero no cs", 64'(cs_falls - c0), 64'd0);
    chk("R8 zero no sck", 64'(pulses - p0), 64'd0);
    chk("R8 zero done", 64'(done_cnt - d0), 64'd1);
  endtask

  task automatic t_extra();
    logic [7:0] b;
    wr(5'h01, 8'd8);
    launch(8'h0C);
    wait_idle();
    chk("R9 extra pulse", 64'(pulses_l - pl0), 64'd9);
    chk("R9 base ignores hint", 64'(pulses - p0), 64'd8);
    @(negedge clk); rd_addr = 5'h10; @(negedge clk); b = rd_data_l;
    chk("R9 late rx0", 64'(b), 64'hFF);
    @(negedge clk); rd_addr = 5'h11; @(negedge clk); b = rd_data_l;
    chk("R9 late rx1", 64'(b), 64'h01);
    launch(8'h04);
    wait_idle();
    chk("R9 no hint no extra", 64'(pulses_l - pl0), 64'd8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_frame();
    t_partial();
    t_saturate();
    t_reserved();
    t_busy_ignore();
    t_zero();
    t_extra();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule